// File: doc/BRIEF.md
# Dual Countdown Timer Core

This block keeps two hours:minutes:seconds countdown timers that share a single run slot. At most one timer counts at a time. Each timer has its own start/stop pulse. A timer is preset through a load strobe that carries an hours value, a minutes value and a timer select. While a timer is running, it counts down by one second on each one-cycle `sec_tick` pulse. When it reaches zero it stops by itself and latches an alarm bit for that timer.

A readout selector picks either timer and shows its remaining hours and minutes as four BCD digits for a seven-segment display driver. The readout is combinational from the timer state, so an idle timer can be inspected while the other one counts, and counting is not disturbed. The value of 100 hours cannot fit in two digits. It is shown with a separate overflow flag, and the hour digits read 00.

Top module: `dual_countdown_core`

## Requirements
- R1: At most one timer is running at any time (`run_state` is one-hot or zero). If both toggle bits pulse in the same cycle while no timer runs, timer 0 is the one that starts.
- R2: A `run_toggle[i]` pulse pauses timer i if it is running. If timer i is stopped, the pulse starts it only when no timer is running and its count is nonzero. A start request is ignored if another timer runs, if the count is zero, or if the same cycle also loads that timer.
- R3: A load (`load_stb`, target `load_sel`) is accepted only while the target is stopped, and it sets seconds to 0. Hours of 100 or more load 100:00 and force minutes to 0. Minutes above 59 load 59. A load to a running timer is ignored.
- R4: A running timer decrements once per `sec_tick` cycle. Seconds 00 borrow from minutes, giving minutes-1:59. Minutes and seconds both 00 borrow from hours, giving hours-1:59:59. A stopped timer ignores ticks.
- R5: A tick that brings a running timer to 00:00:00 clears its `run_state` bit and sets its `alarm` bit on the same clock edge.
- R6: An `alarm` bit stays set until `alarm_ack` (which clears all alarm bits) or until an accepted load of that same timer. An expiry in the same cycle as `alarm_ack` leaves the alarm set.
- R7: `view_sel` selects the timer shown on `disp_bcd`, with hours tens in [15:12], hours ones in [11:8], minutes tens in [7:4] and minutes ones in [3:0]. The readout follows the state with no register delay and has no effect on counting.
- R8: When the selected timer holds 100 hours, `disp_over` is 1 and the hour digits read 00. Otherwise `disp_over` is 0.
- R9: After reset, both timers are stopped at 00:00:00 with no alarm, and the readout is 0000 with `disp_over` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| run_toggle | input | 2 | Per-timer start/stop pulses |
| load_stb | input | 1 | Preset strobe |
| load_sel | input | 1 | Timer targeted by the preset |
| load_hours | input | 7 | Preset hours, binary |
| load_mins | input | 6 | Preset minutes, binary |
| alarm_ack | input | 1 | Clears all latched alarms |
| view_sel | input | 1 | Timer shown on the readout |
| disp_bcd | output | 16 | HHMM as four BCD digits |
| disp_over | output | 1 | Selected timer holds 100 hours |
| run_state | output | 2 | Running flag per timer |
| alarm | output | 2 | Latched alarm per timer |

## Verification
The assertions check the following on every cycle:
- the single-runner invariant;
- that a running timer never sits at zero;
- the 100-hour cap on stored counts;
- that a paused, unloaded timer holds its count;
- that alarms persist without an acknowledge or load, and rise only on a running timer that has just stopped;
- that every readout digit is a legal BCD value.

Only the bench's scenarios can show the rest:
- the preset clamping values;
- the exact borrow results;
- the full 300-tick expiry time;
- the start priority and the ignored requests;
- alarm precedence over a coincident acknowledge.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int HR_W = 7;
  localparam int MN_W = 6;

  typedef struct packed {
    logic [HR_W-1:0] hh;
    logic [MN_W-1:0] mm;
    logic [MN_W-1:0] ss;
  } tcount_t;

  // binary 0..99 to two BCD digits
  function automatic logic [7:0] bin_to_bcd2(input logic [HR_W-1:0] v);
    logic [HR_W-1:0] tens;
    logic [HR_W-1:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

endpackage

// File: rtl/dct_timer_slot.sv
module dct_timer_slot
  import dct_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    run_en,
  input  logic    load_en,
  input  tcount_t load_val,
  input  logic    ack,
  output tcount_t cnt,
  output logic    is_zero,
  output logic    expire,
  output logic    alarm
);

  tcount_t cnt_q, cnt_d;
  logic    alarm_q, alarm_d;
  logic    last_sec;

  always_comb begin
    is_zero  = (cnt_q == '0);
    last_sec = (cnt_q.hh == '0) && (cnt_q.mm == '0) && (cnt_q.ss == 6'd1);
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (load_en) begin
      cnt_d = load_val;
    end else if (run_en && tick && !is_zero) begin
      expire = last_sec;
      if (cnt_q.ss != '0) begin
        cnt_d.ss = cnt_q.ss - 6'd1;
      end else if (cnt_q.mm != '0) begin
        cnt_d.mm = cnt_q.mm - 6'd1;
        cnt_d.ss = 6'd59;
      end else begin
        cnt_d.hh = cnt_q.hh - 7'd1;
        cnt_d.mm = 6'd59;
        cnt_d.ss = 6'd59;
      end
    end
  end

  always_comb begin
    alarm_d = alarm_q;
    if (ack || load_en) alarm_d = 1'b0;
    if (expire)         alarm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign cnt   = cnt_q;
  assign alarm = alarm_q;

endmodule

// File: rtl/dct_run_arbiter.sv
module dct_run_arbiter #(
  parameter int N_TIMERS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TIMERS-1:0] toggle,
  input  logic [N_TIMERS-1:0] can_start,
  input  logic [N_TIMERS-1:0] expire,
  output logic [N_TIMERS-1:0] run_q
);

  logic [N_TIMERS-1:0] run_d;
  logic                granted;

  always_comb begin
    run_d   = run_q;
    granted = 1'b0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if ((toggle[i] && run_q[i]) || expire[i]) run_d[i] = 1'b0;
    end
    if (run_q == '0) begin
      for (int i = 0; i < N_TIMERS; i++) begin
        if (!granted && toggle[i] && can_start[i]) begin
          run_d[i] = 1'b1;
          granted  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

endmodule

// File: rtl/dct_readout.sv
module dct_readout
  import dct_pkg::*;
#(
  parameter int N_TIMERS  = 2,
  parameter int MAX_HOURS = 100,
  parameter int SEL_W     = 1
) (
  input  tcount_t [N_TIMERS-1:0] cnts,
  input  logic    [SEL_W-1:0]    view_sel,
  output logic    [15:0]         bcd,
  output logic                   over
);

  tcount_t         shown;
  logic [HR_W-1:0] hrs;

  always_comb begin
    shown = cnts[view_sel];
    over  = (shown.hh >= HR_W'(MAX_HOURS));
    hrs   = over ? '0 : shown.hh;
    bcd   = {bin_to_bcd2(hrs), bin_to_bcd2({1'b0, shown.mm})};
  end

endmodule

// File: rtl/dual_countdown_core.sv
module dual_countdown_core
  import dct_pkg::*;
#(
  parameter  int N_TIMERS  = 2,
  parameter  int MAX_HOURS = 100,
  localparam int SEL_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic [N_TIMERS-1:0] run_toggle,
  input  logic                load_stb,
  input  logic [SEL_W-1:0]    load_sel,
  input  logic [HR_W-1:0]     load_hours,
  input  logic [MN_W-1:0]     load_mins,
  input  logic                alarm_ack,
  input  logic [SEL_W-1:0]    view_sel,
  output logic [15:0]         disp_bcd,
  output logic                disp_over,
  output logic [N_TIMERS-1:0] run_state,
  output logic [N_TIMERS-1:0] alarm
);

  logic                   rst_meta, rst_sync;
  logic [N_TIMERS-1:0]    load_acc, can_start, expire, is_zero;
  tcount_t [N_TIMERS-1:0] cnt_all;
  tcount_t                load_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // preset clamping
  always_comb begin
    load_val.ss = '0;
    if (load_hours >= HR_W'(MAX_HOURS)) begin
      load_val.hh = HR_W'(MAX_HOURS);
      load_val.mm = '0;
    end else begin
      load_val.hh = load_hours;
      load_val.mm = (load_mins > 6'd59) ? 6'd59 : load_mins;
    end
  end

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_slot
    assign load_acc[g]  = load_stb && (load_sel == SEL_W'(g)) && !run_state[g];
    assign can_start[g] = !is_zero[g] && !load_acc[g];

    dct_timer_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_sync),
      .tick     (sec_tick),
      .run_en   (run_state[g]),
      .load_en  (load_acc[g]),
      .load_val (load_val),
      .ack      (alarm_ack),
      .cnt      (cnt_all[g]),
      .is_zero  (is_zero[g]),
      .expire   (expire[g]),
      .alarm    (alarm[g])
    );
  end

  dct_run_arbiter #(.N_TIMERS(N_TIMERS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync),
    .toggle    (run_toggle),
    .can_start (can_start),
    .expire    (expire),
    .run_q     (run_state)
  );

  dct_readout #(.N_TIMERS(N_TIMERS), .MAX_HOURS(MAX_HOURS), .SEL_W(SEL_W)) u_view (
    .cnts     (cnt_all),
    .view_sel (view_sel),
    .bcd      (disp_bcd),
    .over     (disp_over)
  );

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int N_TIMERS  = 2,
  parameter int MAX_HOURS = 100,
  parameter int SEL_W     = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alarm_ack,
  input logic                   load_stb,
  input logic [SEL_W-1:0]       load_sel,
  input logic [N_TIMERS-1:0]    run_state,
  input logic [N_TIMERS-1:0]    alarm,
  input logic [15:0]            disp_bcd,
  input logic                   disp_over,
  input tcount_t [N_TIMERS-1:0] cnt_all
);

  a_r1_one_runner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_state));

  a_r8_over_digits: assert property (@(posedge clk) disable iff (!rst_n)
    disp_over |-> (disp_bcd[15:8] == 8'h00));

  a_r7_bcd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bcd[15:12] <= 4'd9) && (disp_bcd[11:8] <= 4'd9) &&
    (disp_bcd[7:4] <= 4'd5) && (disp_bcd[3:0] <= 4'd9));

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
    logic ld;
    assign ld = load_stb && (load_sel == SEL_W'(i)) && !run_state[i];

    a_r5_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      run_state[i] |-> (cnt_all[i] != '0));

    a_r3_hours_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_all[i].hh <= HR_W'(MAX_HOURS)) &&
      ((cnt_all[i].hh != HR_W'(MAX_HOURS)) || ((cnt_all[i].mm == '0) && (cnt_all[i].ss == '0))));

    a_r4_paused_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_state[i] && !ld) |=> $stable(cnt_all[i]));

    a_r6_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm[i] && !alarm_ack && !ld) |=> alarm[i]);

    a_r5_alarm_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm[i]) |-> ($past(run_state[i]) && !run_state[i]));
  end

endmodule

bind dual_countdown_core dct_checker #(
  .N_TIMERS(N_TIMERS), .MAX_HOURS(MAX_HOURS), .SEL_W(SEL_W)
) u_dct_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .alarm_ack (alarm_ack),
  .load_stb  (load_stb),
  .load_sel  (load_sel),
  .run_state (run_state),
  .alarm     (alarm),
  .disp_bcd  (disp_bcd),
  .disp_over (disp_over),
  .cnt_all   (cnt_all)
);

// File: tb/test_dual_countdown_core.sv
module test_dual_countdown_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick;
  logic [1:0]  run_toggle;
  logic        load_stb;
  logic [0:0]  load_sel;
  logic [6:0]  load_hours;
  logic [5:0]  load_mins;
  logic        alarm_ack;
  logic [0:0]  view_sel;
  logic [15:0] disp_bcd;
  logic        disp_over;
  logic [1:0]  run_state;
  logic [1:0]  alarm;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dual_countdown_core i_dual_countdown_core (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run_toggle(run_toggle),
    .load_stb(load_stb), .load_sel(load_sel), .load_hours(load_hours),
    .load_mins(load_mins), .alarm_ack(alarm_ack), .view_sel(view_sel),
    .disp_bcd(disp_bcd), .disp_over(disp_over), .run_state(run_state), .alarm(alarm)
  );

  // {hours_in, mins_in, expected digits, expected overflow}
  localparam logic [29:0] VEC [8] = '{
    {7'd5,   6'd30, 16'h0530, 1'b0},
    {7'd99,  6'd59, 16'h9959, 1'b0},
    {7'd100, 6'd0,  16'h0000, 1'b1},
    {7'd100, 6'd45, 16'h0000, 1'b1},
    {7'd120, 6'd10, 16'h0000, 1'b1},
    {7'd12,  6'd63, 16'h1259, 1'b0},
    {7'd0,   6'd0,  16'h0000, 1'b0},
    {7'd7,   6'd8,  16'h0708, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic s, input logic [6:0] h, input logic [5:0] m);
    load_sel = s; load_hours = h; load_mins = m; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic do_tog(input logic [1:0] v);
    run_toggle = v;
    @(negedge clk);
    run_toggle = 2'b00;
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sec_tick = 0; run_toggle = 0; load_stb = 0; load_sel = 0;
    load_hours = 0; load_mins = 0; alarm_ack = 0; view_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9 run_state", 32'(run_state), 32'h0);
    chk("R9 alarm", 32'(alarm), 32'h0);
    chk("R9 readout", {15'd0, disp_over, disp_bcd}, 32'h0);

    // R3 R7 R8 preset clamping and readout vectors
    for (int v = 0; v < 8; v++) begin
      do_load(1'b0, VEC[v][29:23], VEC[v][22:17]);
      chk("R3 R7 R8 vector", {15'd0, disp_over, disp_bcd}, {15'd0, VEC[v][0], VEC[v][16:1]});
    end

    // R2 start with zero count is ignored
    do_load(1'b1, 7'd0, 6'd0);
    do_tog(2'b10);
    chk("R2 zero start ignored", 32'(run_state), 32'h0);

    do_load(1'b0, 7'd1, 6'd0);
    do_load(1'b1, 7'd0, 6'd5);
    do_tog(2'b01);
    chk("R2 start timer0", 32'(run_state), 32'h1);

    // R1 second start while one runs is ignored
    do_tog(2'b10);
    chk("R1 exclusion", 32'(run_state), 32'h1);

    // R3 load to a running timer ignored
    do_load(1'b0, 7'd3, 6'd3);
    chk("R3 load while running", 32'(disp_bcd), 32'h0100);

    // R4 hours borrow
    do_tick(1);
    chk("R4 hour borrow", 32'(disp_bcd), 32'h0059);

    // R7 view idle timer while other runs
    view_sel = 1'b1;
    @(negedge clk);
    chk("R7 idle view", 32'(disp_bcd), 32'h0005);
    chk("R7 still running", 32'(run_state), 32'h1);
    view_sel = 1'b0;

    // R2 pause, R4 paused ignores ticks
    do_tog(2'b01);
    chk("R2 pause", 32'(run_state), 32'h0);
    do_tick(5);
    chk("R4 paused holds", 32'(disp_bcd), 32'h0059);

    // R1 simultaneous starts: timer0 wins
    do_tog(2'b11);
    chk("R1 priority", 32'(run_state), 32'h1);
    do_tog(2'b01);
    do_tog(2'b10);
    chk("R2 start timer1", 32'(run_state), 32'h2);

    // R5 expiry after 5 minutes of ticks
    view_sel = 1'b1;
    do_tick(1);
    chk("R4 minute borrow", 32'(disp_bcd), 32'h0004);
    do_tick(298);
    chk("R5 one second left", {28'd0, alarm, run_state}, 32'h2);
    do_tick(1);
    chk("R5 stop at zero", 32'(run_state), 32'h0);
    chk("R5 alarm set", 32'(alarm), 32'h2);
    chk("R5 readout zero", 32'(disp_bcd), 32'h0000);

    // R6 alarm stays until acknowledged
    do_tick(3);
    chk("R6 alarm held", 32'(alarm), 32'h2);
    alarm_ack = 1'b1;
    @(negedge clk);
    alarm_ack = 1'b0;
    chk("R6 ack clears", 32'(alarm), 32'h0);

    // R6 load clears only its own timer's alarm
    do_load(1'b1, 7'd0, 6'd1);
    do_tog(2'b10);
    do_tick(60);
    chk("R6 alarm again", 32'(alarm), 32'h2);
    do_load(1'b0, 7'd0, 6'd9);
    chk("R6 other load keeps", 32'(alarm), 32'h2);
    do_load(1'b1, 7'd2, 6'd0);
    chk("R6 own load clears", 32'(alarm), 32'h0);

    // R6 expiry wins over coincident ack
    do_load(1'b1, 7'd0, 6'd1);
    do_tog(2'b10);
    do_tick(59);
    sec_tick = 1'b1; alarm_ack = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; alarm_ack = 1'b0;
    chk("R6 expiry over ack", 32'(alarm), 32'h2);

    // R2 start ignored when loaded in same cycle
    load_sel = 1'b0; load_hours = 7'd1; load_mins = 6'd0; load_stb = 1'b1;
    run_toggle = 2'b01;
    @(negedge clk);
    load_stb = 1'b0; run_toggle = 2'b00;
    chk("R2 start with load ignored", 32'(run_state), 32'h0);

    finish_run();
  end

endmodule